// File: doc/BRIEF.md
# Multi-Port Read-Only Line Cache with Write-Around Stores

This block is a direct-mapped data cache placed between a group of thread processors and a shared backing memory. Every load passes through it on one of several independent read ports, and each port can look up a word in the same cycle as the others. A port that finds its line present is answered in the cycle it asks; a port that does not waits while the cache fetches the whole line from the backing memory, one fetch at a time.

Stores never touch the cache. They flow straight through to a separate write port that feeds the output image buffer, so frame writes cannot evict or alter scene data. Between frames the owner pulses an invalidate input, which empties the whole cache at once so the next frame starts cold against fresh scene data.

Top module: `ro_wa_cache`

## Requirements
- R1: A read port with `rd_valid` high whose line is present raises `rd_ack` in that same cycle, and `rd_data` carries the 32-bit word selected by address bits [OFF_W-1:2] of the line (word k holds bits [32k+31:32k] of the fetched line).
- R2: A port whose line is absent causes a fetch: `mem_req` rises one cycle later with `mem_addr` equal to the request address with its low OFF_W bits cleared; the line returned on `mem_rvalid`/`mem_rdata` is installed, and the port is acknowledged with the correct word in the cycle after the fill.
- R3: After reset every line is invalid, `mem_req` is low and no port is acknowledged until its line has been fetched.
- R4: The line index is address bits [OFF_W+IDX_W-1:OFF_W] and the tag is the remaining upper bits; a fill for one tag replaces any other tag held at the same index, while other indices are untouched.
- R5: When several ports miss together, fetches are issued one at a time, lowest-numbered port first; a new fetch starts only after the previous fill has completed.
- R6: A port that hits completes without waiting while another port is missing or a fetch is in flight.
- R7: Ports that miss on the same line are all satisfied by a single fetch.
- R8: A store presented on `st_valid`/`st_addr`/`st_data` appears on `wr_valid`/`wr_addr`/`wr_data` in the same cycle, starts no fetch, and leaves cached contents unchanged.
- R9: A pulse on `inval` clears every valid bit, so no port hits in the following cycle; a fill arriving in the same cycle as `inval` is not kept.
- R10: Once raised, `mem_req` stays high with a constant `mem_addr` until `mem_rvalid` is seen, and drops in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval | input | 1 | Clear all lines |
| rd_valid | input | NPORTS | Load request per port, held until acknowledged |
| rd_addr | input | NPORTS*ADDR_W | Byte address per port, port p at bits [p*ADDR_W +: ADDR_W] |
| rd_ack | output | NPORTS | Load completes this cycle |
| rd_data | output | NPORTS*32 | Loaded word per port |
| mem_req | output | 1 | Line fetch outstanding |
| mem_addr | output | ADDR_W | Line-aligned fetch address |
| mem_rvalid | input | 1 | Fetched line is present on mem_rdata |
| mem_rdata | input | LINE_BYTES*8 | Fetched line |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store address |
| st_data | input | 32 | Store data |
| wr_valid | output | 1 | Store towards output buffer |
| wr_addr | output | ADDR_W | Output buffer address |
| wr_data | output | 32 | Output buffer data |

## Verification
The bench builds the cache with three ports, eight lines of sixteen bytes and a 12-bit address, so every index, every word position and tag conflicts are all reachable in a short run. With so few lines the whole cache is filled and swept, evictions between tags at one index are forced directly, and the fetch latency of the memory model is varied so that acknowledge cycles can be predicted arithmetically for single misses, three-way serialized misses and invalidates that collide with a fill.

// File: rtl/ro_wa_cache.sv
module ro_wa_cache #(
  parameter int NPORTS     = 3,
  parameter int ADDR_W     = 32,
  parameter int LINES      = 2048,
  parameter int LINE_BYTES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inval,
  input  logic [NPORTS-1:0]          rd_valid,
  input  logic [NPORTS*ADDR_W-1:0]   rd_addr,
  output logic [NPORTS-1:0]          rd_ack,
  output logic [NPORTS*32-1:0]       rd_data,
  output logic                       mem_req,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic                       mem_rvalid,
  input  logic [LINE_BYTES*8-1:0]    mem_rdata,
  input  logic                       st_valid,
  input  logic [ADDR_W-1:0]          st_addr,
  input  logic [31:0]                st_data,
  output logic                       wr_valid,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [31:0]                wr_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WSEL_W = OFF_W - 2;

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];
  logic [LINES-1:0]  vld_q;

  logic              busy_q;
  logic [ADDR_W-1:0] fetch_q;
  logic [NPORTS-1:0] miss;
  logic [ADDR_W-1:0] port_addr [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tg;
    logic [WSEL_W-1:0] ws;
    logic              hit;
    assign port_addr[p] = rd_addr[p*ADDR_W +: ADDR_W];
    assign idx = port_addr[p][OFF_W +: IDX_W];
    assign tg  = port_addr[p][ADDR_W-1 -: TAG_W];
    assign ws  = port_addr[p][2 +: WSEL_W];
    assign hit = vld_q[idx] && (tag_q[idx] == tg);
    assign rd_ack[p]  = rd_valid[p] & hit;
    assign miss[p]    = rd_valid[p] & ~hit;
    assign rd_data[p*32 +: 32] = data_q[idx][ws*32 +: 32];
  end

  logic              any_miss;
  logic [ADDR_W-1:0] pick_addr;
  always_comb begin
    any_miss  = 1'b0;
    pick_addr = '0;
    for (int i = NPORTS - 1; i >= 0; i--)
      if (miss[i]) begin
        any_miss  = 1'b1;
        pick_addr = port_addr[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fetch_q <= '0;
    end else if (!busy_q && any_miss) begin
      busy_q  <= 1'b1;
      fetch_q <= {pick_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end else if (busy_q && mem_rvalid) begin
      busy_q  <= 1'b0;
    end
  end

  wire              fill  = busy_q & mem_rvalid;
  wire [IDX_W-1:0]  f_idx = fetch_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  f_tag = fetch_q[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[f_idx]  <= f_tag;
      data_q[f_idx] <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || inval) vld_q <= '0;
    else if (fill)       vld_q[f_idx] <= 1'b1;
  end

  assign mem_req  = busy_q;
  assign mem_addr = fetch_q;

  assign wr_valid = st_valid;
  assign wr_addr  = st_addr;
  assign wr_data  = st_data;
endmodule

// File: rtl/ro_wa_cache_chk.sv
module ro_wa_cache_chk #(
  parameter int NPORTS     = 3,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inval,
  input logic [NPORTS-1:0] rd_valid,
  input logic [NPORTS-1:0] rd_ack,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  p_fetch_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(|(rd_valid & ~rd_ack)));

  p_inval_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> (rd_ack == '0));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid) |=> !mem_req);
endmodule

bind ro_wa_cache ro_wa_cache_chk #(
  .NPORTS(NPORTS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inval(inval), .rd_valid(rd_valid),
  .rd_ack(rd_ack), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid)
);

// File: tb/ro_wa_cache_tb.sv
`timescale 1ns/1ps
module ro_wa_cache_tb;
  localparam int NP = 3, AW = 12, NL = 8, LB = 16;

  logic clk = 0, rst_n = 0, inval = 0;
  logic [NP-1:0] rd_valid = '0;
  logic [NP*AW-1:0] rd_addr = '0;
  logic [NP-1:0] rd_ack;
  logic [NP*32-1:0] rd_data;
  logic mem_req, mem_rvalid = 0;
  logic [AW-1:0] mem_addr;
  logic [LB*8-1:0] mem_rdata = '0;
  logic st_valid = 0;
  logic [AW-1:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;

  always #4 clk = ~clk;

  ro_wa_cache #(.NPORTS(NP), .ADDR_W(AW), .LINES(NL), .LINE_BYTES(LB)) u_dut (
    .clk(clk), .rst_n(rst_n), .inval(inval), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .st_valid(st_valid),
    .st_addr(st_addr), .st_data(st_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data));

  int total = 0, fails = 0, done = 0;
  int mem_lat = 2, wait_cnt = 0, fill_cnt = 0, viol = 0;
  logic [AW-1:0] fill_log [64];
  logic prev_req = 0, prev_rv = 0;
  logic [AW-1:0] prev_addr = '0;
  int res_cyc [NP];
  logic [31:0] res_dat [NP];

  function automatic logic [31:0] mword(input logic [AW-1:0] a);
    return {6'd0, a[11:2], 6'h2a, ~a[11:2]};
  endfunction

  function automatic logic [LB*8-1:0] mline(input logic [AW-1:0] a);
    logic [AW-1:0] b = {a[AW-1:4], 4'h0};
    return {mword(b + 12), mword(b + 8), mword(b + 4), mword(b)};
  endfunction

  always @(negedge clk) begin
    if (prev_req && mem_req && !prev_rv && mem_addr != prev_addr) viol++;
    prev_req = mem_req; prev_addr = mem_addr;
    mem_rvalid = 0;
    if (mem_req) begin
      if (wait_cnt >= mem_lat) begin
        mem_rvalid = 1;
        mem_rdata = mline(mem_addr);
        fill_log[fill_cnt % 64] = mem_addr;
        fill_cnt++;
        wait_cnt = 0;
      end else wait_cnt++;
    end else wait_cnt = 0;
    prev_rv = mem_rvalid;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_loads(input logic [NP-1:0] en, input logic [AW-1:0] a0, a1, a2);
    logic [NP-1:0] pend;
    int c = 0;
    @(negedge clk);
    rd_addr = {a2, a1, a0};
    rd_valid = en; pend = en;
    for (int p = 0; p < NP; p++) res_cyc[p] = -1;
    while (pend != 0 && c < 300) begin
      #1;
      for (int p = 0; p < NP; p++)
        if (pend[p] && rd_ack[p]) begin
          res_cyc[p] = c; res_dat[p] = rd_data[p*32 +: 32]; pend[p] = 0;
        end
      @(negedge clk);
      rd_valid = pend; c++;
    end
    rd_valid = '0;
  endtask

  task automatic one(input int p, input logic [AW-1:0] a, input int exp_cyc, input string req);
    logic [NP-1:0] en = NP'(1) << p;
    run_loads(en, a, a, a);
    chk(res_cyc[p] == exp_cyc, req, res_cyc[p], exp_cyc);
    chk(res_dat[p] == mword(a), req, res_dat[p], mword(a));
  endtask

  task automatic pulse_inval();
    @(negedge clk); inval = 1;
    @(negedge clk); inval = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int f0;
    logic [AW-1:0] a;
    repeat (3) @(negedge clk);
    #1;
    chk(mem_req == 0, "R3 req after reset", mem_req, 0);
    @(negedge clk); rst_n = 1;
    #1;
    chk(mem_req == 0 && rd_ack == 0, "R3 idle", {mem_req, rd_ack}, 0);

    // R2/R3: cold sweep of all lines, tag 0, lat 2
    for (int l = 0; l < NL; l++) begin
      a = AW'(l * 16 + (l % 4) * 4);
      f0 = fill_cnt;
      one(0, a, mem_lat + 2, "R2 cold miss");
      chk(fill_log[f0 % 64] == {a[AW-1:4], 4'h0}, "R2 fetch addr", fill_log[f0 % 64], {a[AW-1:4], 4'h0});
    end
    // R1: every word of every line hits on rotating ports
    for (int l = 0; l < NL; l++)
      for (int w = 0; w < 4; w++)
        one((l + w) % NP, AW'(l * 16 + w * 4), 0, "R1 hit word");

    // R2: other latencies
    mem_lat = 0; one(1, 12'h184, 2, "R2 lat0");
    mem_lat = 5; one(2, 12'h2c8, 7, "R2 lat5");
    mem_lat = 2;

    // R4: conflict at index 2, index 3 unaffected
    one(0, 12'h520, 4, "R4 new tag miss");
    one(0, 12'h020, 4, "R4 evicted refetch");
    one(1, 12'h030, 0, "R4 other index kept");
    one(2, 12'h524, 4, "R4 evicted by refill");

    // R5: three misses serialized in port order
    pulse_inval();
    f0 = fill_cnt;
    run_loads(3'b111, 12'h714, 12'h358, 12'h46c);
    for (int p = 0; p < NP; p++)
      chk(res_cyc[p] == (p + 1) * (mem_lat + 2), "R5 order cycle", res_cyc[p], (p + 1) * (mem_lat + 2));
    chk(fill_log[f0 % 64] == 12'h710, "R5 first fetch port0", fill_log[f0 % 64], 12'h710);
    chk(fill_log[(f0 + 1) % 64] == 12'h350, "R5 second fetch port1", fill_log[(f0 + 1) % 64], 12'h350);
    chk(fill_log[(f0 + 2) % 64] == 12'h460, "R5 third fetch port2", fill_log[(f0 + 2) % 64], 12'h460);
    chk(res_dat[2] == mword(12'h46c), "R5 data", res_dat[2], mword(12'h46c));

    // R6: hit beside a miss
    run_loads(3'b011, 12'h0a8, 12'h358, 12'h0);
    chk(res_cyc[1] == 0, "R6 hit no wait", res_cyc[1], 0);
    chk(res_cyc[0] == mem_lat + 2, "R6 miss", res_cyc[0], mem_lat + 2);
    chk(res_dat[1] == mword(12'h358), "R6 hit data", res_dat[1], mword(12'h358));

    // R7: same line on two ports
    f0 = fill_cnt;
    run_loads(3'b110, 12'h0, 12'h6f4, 12'h6f8);
    chk(fill_cnt - f0 == 1, "R7 one fetch", fill_cnt - f0, 1);
    chk(res_cyc[1] == mem_lat + 2 && res_cyc[2] == mem_lat + 2, "R7 both done", {res_cyc[1], res_cyc[2]}, mem_lat + 2);
    chk(res_dat[2] == mword(12'h6f8), "R7 data", res_dat[2], mword(12'h6f8));

    // R8: stores pass through and leave cache alone
    f0 = fill_cnt;
    @(negedge clk); st_valid = 1; st_addr = 12'h6f4; st_data = 32'hdeadbeef;
    #1;
    chk(wr_valid && wr_addr == 12'h6f4 && wr_data == 32'hdeadbeef, "R8 passthrough", wr_data, 32'hdeadbeef);
    @(negedge clk); st_addr = 12'h9a0; st_data = 32'h12345678;
    @(negedge clk); st_valid = 0;
    #1;
    chk(wr_valid == 0, "R8 store end", wr_valid, 0);
    repeat (3) @(negedge clk);
    chk(mem_req == 0 && fill_cnt == f0, "R8 no fetch", fill_cnt - f0, 0);
    one(0, 12'h6f4, 0, "R8 cached value unchanged");

    // R9: invalidate then reload
    pulse_inval();
    f0 = fill_cnt;
    one(1, 12'h6f4, mem_lat + 2, "R9 miss after inval");
    chk(fill_cnt - f0 == 1, "R9 refetch", fill_cnt - f0, 1);
    // R9: invalidate colliding with the fill
    f0 = fill_cnt;
    fork
      run_loads(3'b001, 12'h3b0, 12'h0, 12'h0);
      begin repeat (mem_lat + 2) @(negedge clk); inval = 1; @(negedge clk); inval = 0; end
    join
    chk(res_cyc[0] == 2 * (mem_lat + 2), "R9 fill dropped", res_cyc[0], 2 * (mem_lat + 2));
    chk(fill_cnt - f0 == 2, "R9 second fetch", fill_cnt - f0, 2);

    chk(viol == 0, "R10 request held stable", viol, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule